// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is a combinational 32-bit arithmetic-logic unit paired with the decoder that picks its operation. The main controller supplies a 2-bit operation class. For arithmetic instructions the decoder also reads the 6-bit function field taken from the low bits of the instruction word. The decoder turns these two inputs into a 3-bit operation select. The ALU then applies that select to two operands and produces a result and a zero flag. The branch logic uses the zero flag to resolve branch-on-equal.

Subtract and set-on-less-than share the top bit of the select. When that bit is set, the operand B path is inverted and a carry-in of one is added, so one adder serves add, subtract and the signed compare. The compare takes the sign of the difference and corrects it for overflow. No clock or state is involved: every output follows the inputs within the same cycle.

Top module: `alu_top`

## Requirements
- R1: Operation class 00 (memory address) selects add (select 010) for every function field value.
- R2: Operation class 01 (branch compare) selects subtract (select 110) for every function field value.
- R3: With class 10, function code 100000 selects add, and the result is A+B modulo 2^32.
- R4: With class 10, function code 100010 selects subtract, and the result is A-B modulo 2^32.
- R5: With class 10, function code 100100 selects AND (select 000), and the result is the bitwise AND.
- R6: With class 10, function code 100101 selects OR (select 001), and the result is the bitwise OR.
- R7: With class 10, function code 101010 selects set-on-less-than (select 111). The result is 1 in bit 0 with all other bits 0 when A < B as signed numbers, and 0 otherwise. This includes operand pairs whose difference overflows.
- R8: Class 11, and class 10 with any function code other than the five above, select add (select 010).
- R9: The zero output is 1 exactly when all 32 result bits are 0.
- R10: The select output is always one of 000, 001, 010, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| alu_sel | output | 3 | Decoded operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest case to reach is a signed compare whose difference overflows. In that case the raw sign bit of the difference gives the wrong answer. Random operands seldom produce it, so the stimulus drives the extreme pairs on purpose: the most negative and most positive values against each other and against small values of the opposite sign. The zero flag is driven to one on purpose by subtracting equal operands and by ANDing disjoint masks. Random function codes exercise the fallback to add.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int FUNCT_W = 6;

    typedef enum logic [2:0] {
        SEL_AND = 3'b000,
        SEL_OR  = 3'b001,
        SEL_ADD = 3'b010,
        SEL_SUB = 3'b110,
        SEL_SLT = 3'b111
    } alu_sel_e;

    localparam logic [1:0] CLS_MEM   = 2'b00;
    localparam logic [1:0] CLS_BR    = 2'b01;
    localparam logic [1:0] CLS_ARITH = 2'b10;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_sel_e           sel
);
    typedef struct packed {
        alu_sel_e fn_sel;
        alu_sel_e sel;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d = '{fn_sel: SEL_ADD, sel: SEL_ADD};
        unique case (funct)
            FN_ADD:  dec_d.fn_sel = SEL_ADD;
            FN_SUB:  dec_d.fn_sel = SEL_SUB;
            FN_AND:  dec_d.fn_sel = SEL_AND;
            FN_OR:   dec_d.fn_sel = SEL_OR;
            FN_SLT:  dec_d.fn_sel = SEL_SLT;
            default: dec_d.fn_sel = SEL_ADD;
        endcase
        unique case (op_class)
            CLS_MEM:   dec_d.sel = SEL_ADD;
            CLS_BR:    dec_d.sel = SEL_SUB;
            CLS_ARITH: dec_d.sel = dec_d.fn_sel;
            default:   dec_d.sel = SEL_ADD;
        endcase
    end

    assign sel = dec_d.sel;

    // R1 / R2: fixed classes ignore the function field
    always_comb begin
        a_r1_mem_add: assert (op_class != CLS_MEM || sel == SEL_ADD);
        a_r2_br_sub:  assert (op_class != CLS_BR || sel == SEL_SUB);
        a_r8_cls3_add: assert (op_class != 2'b11 || sel == SEL_ADD);
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    output logic [WIDTH-1:0] sum,
    output logic             less
);
    typedef struct packed {
        logic [WIDTH-1:0] b_eff;
        logic [WIDTH-1:0] sum;
        logic             ovf;
        logic             less;
    } as_t;

    as_t as_d;

    always_comb begin
        as_d.b_eff = invert_b ? ~b : b;
        as_d.sum   = a + as_d.b_eff + {{(WIDTH-1){1'b0}}, invert_b};
        as_d.ovf   = (a[WIDTH-1] == as_d.b_eff[WIDTH-1]) &&
                     (as_d.sum[WIDTH-1] != a[WIDTH-1]);
        as_d.less  = as_d.sum[WIDTH-1] ^ as_d.ovf;
    end

    assign sum  = as_d.sum;
    assign less = as_d.less;

    // R7: overflow-corrected sign agrees with a direct signed compare
    always_comb begin
        a_r7_signed_less: assert (!invert_b || (less == ($signed(a) < $signed(b))));
        a_r4_sub_inverse: assert (!invert_b || (sum + b == a));
    end
endmodule

// File: rtl/alu_top.sv
module alu_top
    import alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    output logic [2:0]         alu_sel,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zero;
    } out_t;

    alu_sel_e         sel;
    logic [WIDTH-1:0] sum;
    logic             less;
    out_t             out_d;

    alu_op_decode i_dec (
        .op_class (op_class),
        .funct    (funct),
        .sel      (sel)
    );

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .a        (opa),
        .b        (opb),
        .invert_b (sel[2]),
        .sum      (sum),
        .less     (less)
    );

    always_comb begin
        out_d.res = sum;
        unique case (sel)
            SEL_AND: out_d.res = opa & opb;
            SEL_OR:  out_d.res = opa | opb;
            SEL_SLT: out_d.res = {{(WIDTH-1){1'b0}}, less};
            default: out_d.res = sum;
        endcase
        out_d.zero = ~|out_d.res;
    end

    assign alu_sel = sel;
    assign result  = out_d.res;
    assign zero    = out_d.zero;

    always_comb begin
        a_r9_zero_flag: assert (zero == (result == '0));
        a_r7_slt_upper: assert (sel != SEL_SLT || result[WIDTH-1:1] == '0);
        a_r10_sel_legal: assert (alu_sel inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111});
    end
endmodule

// File: tb/test_alu_top.sv
module test_alu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic [5:0]  funct = 6'b0;
    logic [31:0] opa = 32'b0;
    logic [31:0] opb = 32'b0;
    logic [2:0]  alu_sel;
    logic [31:0] result;
    logic        zero;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [2:0]  sel;
        logic [31:0] res;
        logic        zero;
    } item_t;

    item_t sb_q[$];

    alu_top i_alu_top (
        .op_class (op_class),
        .funct    (funct),
        .opa      (opa),
        .opb      (opb),
        .alu_sel  (alu_sel),
        .result   (result),
        .zero     (zero)
    );

    always #2.5 clk = ~clk;

    function automatic logic [2:0] model_sel(logic [1:0] c, logic [5:0] f);
        if (c == 2'b00) return 3'b010;
        if (c == 2'b01) return 3'b110;
        if (c == 2'b11) return 3'b010;
        case (f)
            6'b100000: return 3'b010;
            6'b100010: return 3'b110;
            6'b100100: return 3'b000;
            6'b100101: return 3'b001;
            6'b101010: return 3'b111;
            default:   return 3'b010;
        endcase
    endfunction

    function automatic logic [31:0] model_res(logic [2:0] s, logic [31:0] a, logic [31:0] b);
        case (s)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b110: return a - b;
            3'b111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic drive(string tag, logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b);
        item_t it;
        @(negedge clk);
        op_class = c; funct = f; opa = a; opb = b;
        it.tag  = tag;
        it.sel  = model_sel(c, f);
        it.res  = model_res(it.sel, a, b);
        it.zero = (it.res == 32'd0);
        sb_q.push_back(it);
    endtask

    // monitor: pops one expected item per rising edge
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (alu_sel !== it.sel || result !== it.res || zero !== it.zero) begin
                n_fail++;
                $display("FAIL %s: sel=%b res=%h zero=%b expected sel=%b res=%h zero=%b",
                         it.tag, alu_sel, result, zero, it.sel, it.res, it.zero);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state: all inputs zero gives add of zeros (R1, R9)
        drive("R1 reset idle", 2'b00, 6'b0, 32'd0, 32'd0);
        drive("R1 mem add", 2'b00, 6'b100010, 32'h1000_0000, 32'h0000_0064);
        drive("R1 mem add neg offset", 2'b00, 6'b101010, 32'h0000_0100, 32'hFFFF_FFF0);
        drive("R2 br equal", 2'b01, 6'b100000, 32'h1234_5678, 32'h1234_5678);
        drive("R2 br differ", 2'b01, 6'b100100, 32'h0000_0005, 32'h0000_0007);
        drive("R3 add", 2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001);
        drive("R3 add wrap", 2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001);
        drive("R4 sub", 2'b10, 6'b100010, 32'h0000_0003, 32'h0000_0005);
        drive("R4 sub min", 2'b10, 6'b100010, 32'h8000_0000, 32'h0000_0001);
        drive("R5 and", 2'b10, 6'b100100, 32'hF0F0_F0F0, 32'hFF00_FF00);
        drive("R5 and disjoint", 2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555);
        drive("R6 or", 2'b10, 6'b100101, 32'hAAAA_0000, 32'h0000_5555);
        drive("R6 or zeros", 2'b10, 6'b100101, 32'h0, 32'h0);
        drive("R7 slt small", 2'b10, 6'b101010, 32'd3, 32'd9);
        drive("R7 slt equal", 2'b10, 6'b101010, 32'd9, 32'd9);
        drive("R7 slt neg vs pos", 2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1);
        drive("R7 slt min vs max", 2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF);
        drive("R7 slt max vs min", 2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000);
        drive("R7 slt min vs 1", 2'b10, 6'b101010, 32'h8000_0000, 32'd1);
        drive("R7 slt max vs -1", 2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        drive("R8 class3", 2'b11, 6'b100010, 32'd10, 32'd20);
        drive("R8 bad funct", 2'b10, 6'b000000, 32'd10, 32'd20);
        drive("R8 bad funct 2", 2'b10, 6'b100011, 32'hFFFF_FFFE, 32'd2);
        drive("R9 zero sub", 2'b10, 6'b100010, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        drive("R9 zero add", 2'b00, 6'b0, 32'h8000_0000, 32'h8000_0000);
        // R10 plus all classes: random sweep including random function codes
        for (int i = 0; i < 400; i++) begin
            logic [5:0] f;
            f = (i % 3 == 0) ? 6'($urandom) :
                ((i % 5 == 0) ? 6'b100000 : ((i % 5 == 1) ? 6'b100010 :
                ((i % 5 == 2) ? 6'b100100 : ((i % 5 == 3) ? 6'b100101 : 6'b101010))));
            drive("R10 random", 2'($urandom), f, $urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom);
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule